// File: doc/BRIEF.md
# Fractional Audio Master Clock Generator

This block makes the clocks for a serial audio port from a fixed 32 MHz reference. A 32-bit phase accumulator adds a programmable frequency word on every reference edge. Its top bit is the audio master clock, so that clock runs at 32 MHz times the word divided by 2^32, and non-integer division ratios are allowed. The master clock is then divided by a frame ratio, chosen from a coded table, to give the frame (left/right) clock. A bit clock that carries two samples of the chosen width per frame is generated alongside it.

A mode input selects between master and slave operation. In master mode, with the clock enable set, the block drives all three clocks and a one-cycle frame-start strobe. In slave mode it generates no clocks. It brings the bit and frame clocks in from pins through synchronizers, and it raises the strobe on the synchronized frame-clock fall. Settings that cannot fit the bits of a frame are flagged, and the bit and frame clocks are then held low.

Top module: `audio_clk_gen`

## Requirements
- R1: In master mode with the enable set, `mclk_o` has on average a frequency of 32 MHz × `freq_word_i` / 2^32: one reference cycle per step of the accumulator, with the top bit as the output.
- R2: Frequency words that do not divide 2^32 evenly (for example 0x0B000000, 0x11000000, 0x020C0000) give the same average rate, within one master-clock period over any window.
- R3: `ratio_i` codes 0..8 select the frame divisors 32, 48, 64, 96, 128, 192, 256, 384 and 512 in that order. One frame lasts exactly that many master-clock periods.
- R4: `swidth_i` code 0 selects 8-bit samples, 1 selects 16-bit and 2 selects 24-bit. Every frame holds exactly 2×width rising edges of `bclk_o`, and `bclk_o` changes only on a master-clock transition.
- R5: `lrck_o` is low for the first width bit periods of a frame and high for the second half. It changes only in the cycle in which `bclk_o` falls.
- R6: `frame_start_o` is high for exactly one reference cycle per frame, in the cycle in which `lrck_o` goes low.
- R7: With master mode and the enable clear, `mclk_o`, `bclk_o` and `lrck_o` stay low.
- R8: `cfg_err_o` is high when the ratio code is above 8, the width code is 3, or the divisor is below 2×width. A divisor equal to 2×width is legal. While the error is set in master mode, `bclk_o` and `lrck_o` stay low and `mclk_o` still runs.
- R9: In slave mode `mclk_o` stays low. `bclk_o` and `lrck_o` follow `bclk_pin_i` and `lrck_pin_i` two reference cycles late, and `frame_start_o` pulses for one cycle in the cycle in which the synchronized `lrck_o` falls.
- R10: While `rst_ni` is low, all clock and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (generate clocks), 0 = slave |
| mclk_en_i | input | 1 | Master clock enable |
| freq_word_i | input | 32 | Accumulator increment |
| ratio_i | input | 4 | Frame divisor code (0..8) |
| swidth_i | input | 2 | Sample width code (0=8, 1=16, 2=24) |
| bclk_pin_i | input | 1 | Bit clock from pin (slave) |
| lrck_pin_i | input | 1 | Frame clock from pin (slave) |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock, low = left half |
| frame_start_o | output | 1 | One-cycle strobe at frame start |
| cfg_err_o | output | 1 | Ratio/width combination invalid |

## Verification
The bench measures whole frames in reference cycles. It compares each frame length to ratio × 2^32 / word, so a wrong divisor entry, or a frame counted in bit periods instead of master periods, shows up as a frame that is too long or too short. Within each frame it counts bit-clock rises, and counts them again while the frame clock is high. A bit divider that misses a master-clock edge or drifts gives the wrong count. A frame clock that toggles on a rising bit edge shows up as a timing violation. The boundary where the divisor equals twice the width must run cleanly, and the invalid codes must raise the error and freeze the bit and frame clocks. Slave tests check the two-cycle synchronizer delay, and check that the strobe comes from the synchronized frame-clock fall and not from the raw pin.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  localparam int DIV_W = 10;
  localparam int WB_W  = 5;

  function automatic logic [DIV_W-1:0] ratio_div(input logic [3:0] code);
    case (code)
      4'd0: ratio_div = DIV_W'(32);
      4'd1: ratio_div = DIV_W'(48);
      4'd2: ratio_div = DIV_W'(64);
      4'd3: ratio_div = DIV_W'(96);
      4'd4: ratio_div = DIV_W'(128);
      4'd5: ratio_div = DIV_W'(192);
      4'd6: ratio_div = DIV_W'(256);
      4'd7: ratio_div = DIV_W'(384);
      4'd8: ratio_div = DIV_W'(512);
      default: ratio_div = '0;
    endcase
  endfunction

  function automatic logic [WB_W-1:0] width_bits(input logic [1:0] code);
    case (code)
      2'd0: width_bits = WB_W'(8);
      2'd1: width_bits = WB_W'(16);
      2'd2: width_bits = WB_W'(24);
      default: width_bits = '0;
    endcase
  endfunction
endpackage

// File: rtl/acc_mclk_gen.sv
module acc_mclk_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ACC_W-1:0] word_i,
  output logic             mclk_o,
  output logic             edge_o
);
  logic [ACC_W-1:0] acc_q;
  logic             mclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mclk_d_q <= 1'b0;
    end else if (!run_i) begin
      acc_q    <= '0;
      mclk_d_q <= 1'b0;
    end else begin
      acc_q    <= acc_q + word_i;
      mclk_d_q <= acc_q[ACC_W-1];
    end
  end

  assign mclk_o = acc_q[ACC_W-1];
  // both transitions of mclk are events for the bit divider
  assign edge_o = mclk_o ^ mclk_d_q;

  AST_MCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mclk_o); // R7
endmodule

// File: rtl/frame_div.sv
module frame_div #(
  parameter int DIV_W = 10,
  parameter int WB_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WB_W-1:0]  bits_i,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             fs_o
);
  localparam int ACCB_W = DIV_W + 2;

  logic [ACCB_W-1:0] bacc_q, bacc_n, sum, step, twor;
  logic [WB_W-1:0]   cnt_q, cnt_n;
  logic              bclk_q, bclk_n, lrck_q, lrck_n, fs_q, fs_n;
  logic              hit, fall, last, lr_tog;

  // Bresenham: 4*W bclk toggles spread over 2*R mclk transitions
  always_comb begin
    step   = ACCB_W'(bits_i) << 2;
    twor   = ACCB_W'(div_i) << 1;
    sum    = bacc_q + step;
    hit    = edge_i && (sum >= twor);
    bacc_n = edge_i ? (hit ? sum - twor : sum) : bacc_q;
    bclk_n = hit ? ~bclk_q : bclk_q;
    fall   = hit && bclk_q;
    last   = (cnt_q >= bits_i - WB_W'(1));
    cnt_n  = fall ? (last ? '0 : cnt_q + WB_W'(1)) : cnt_q;
    lr_tog = fall && last;
    lrck_n = lr_tog ? ~lrck_q : lrck_q;
    fs_n   = lr_tog && lrck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bacc_q <= '0; cnt_q <= '0;
      bclk_q <= 1'b0; lrck_q <= 1'b0; fs_q <= 1'b0;
    end else if (!run_i) begin
      bacc_q <= '0; cnt_q <= '0;
      bclk_q <= 1'b0; lrck_q <= 1'b0; fs_q <= 1'b0;
    end else begin
      bacc_q <= bacc_n; cnt_q <= cnt_n;
      bclk_q <= bclk_n; lrck_q <= lrck_n; fs_q <= fs_n;
    end
  end

  assign bclk_o = bclk_q;
  assign lrck_o = lrck_q;
  assign fs_o   = fs_q;

  AST_BCLK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !$stable(bclk_q) |-> $past(edge_i)); // R4
  AST_LRCK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !$stable(lrck_q) |-> !bclk_q && $past(bclk_q)); // R5
  AST_FS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |=> !fs_q); // R6
  AST_FS_LRCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> !lrck_q && $past(lrck_q)); // R6
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] s2_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign s1_o[g] = s1_q;
    assign s2_o[g] = s2_q;
  end
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import audio_clk_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int RATIO_CW  = 4,
  parameter int SWIDTH_CW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 master_i,
  input  logic                 mclk_en_i,
  input  logic [ACC_W-1:0]     freq_word_i,
  input  logic [RATIO_CW-1:0]  ratio_i,
  input  logic [SWIDTH_CW-1:0] swidth_i,
  input  logic                 bclk_pin_i,
  input  logic                 lrck_pin_i,
  output logic                 mclk_o,
  output logic                 bclk_o,
  output logic                 lrck_o,
  output logic                 frame_start_o,
  output logic                 cfg_err_o
);
  localparam int PIN_N = 2;
  localparam int BCLK_IDX = 0;
  localparam int LRCK_IDX = 1;

  logic [DIV_W-1:0] div;
  logic [WB_W-1:0]  bits;
  logic             run_m, run_b, mclk_edge;
  logic             g_bclk, g_lrck, g_fs;
  logic [PIN_N-1:0] pin_s1, pin_s2;
  logic             s_fs_q;

  assign div       = ratio_div(4'(ratio_i));
  assign bits      = width_bits(2'(swidth_i));
  assign cfg_err_o = (div == '0) || (bits == '0) || (div < DIV_W'({bits, 1'b0}));

  assign run_m = master_i && mclk_en_i;
  assign run_b = run_m && !cfg_err_o;

  acc_mclk_gen #(.ACC_W(ACC_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_m),
    .word_i (freq_word_i),
    .mclk_o (mclk_o),
    .edge_o (mclk_edge)
  );

  frame_div #(.DIV_W(DIV_W), .WB_W(WB_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_b),
    .edge_i (mclk_edge),
    .div_i  (div),
    .bits_i (bits),
    .bclk_o (g_bclk),
    .lrck_o (g_lrck),
    .fs_o   (g_fs)
  );

  pin_sync #(.W(PIN_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lrck_pin_i, bclk_pin_i}),
    .s1_o   (pin_s1),
    .s2_o   (pin_s2)
  );

  // strobe lands with the synchronized lrck fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_fs_q <= 1'b0;
    else         s_fs_q <= !master_i && pin_s2[LRCK_IDX] && !pin_s1[LRCK_IDX];
  end

  assign bclk_o        = master_i ? g_bclk : pin_s2[BCLK_IDX];
  assign lrck_o        = master_i ? g_lrck : pin_s2[LRCK_IDX];
  assign frame_start_o = master_i ? g_fs   : s_fs_q;

  AST_SLAVE_NO_MCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !mclk_o); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && mclk_en_i && cfg_err_o ##1 master_i |-> !bclk_o && !lrck_o); // R8
endmodule

// File: tb/test_audio_clk_gen.sv
module test_audio_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b1, en = 1'b0;
  logic [31:0] fw = 32'h2000_0000;
  logic [3:0]  rc = 4'd0;
  logic [1:0]  sw = 2'd1;
  logic        bpin = 1'b0, lpin = 1'b0;
  logic        mclk, bclk, lrck, fs, err;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  audio_clk_gen i_audio_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .mclk_en_i(en),
    .freq_word_i(fw), .ratio_i(rc), .swidth_i(sw),
    .bclk_pin_i(bpin), .lrck_pin_i(lpin),
    .mclk_o(mclk), .bclk_o(bclk), .lrck_o(lrck), .frame_start_o(fs), .cfg_err_o(err)
  );

  localparam int NV = 5;
  localparam logic [31:0] VFW [NV] = '{32'h2000_0000, 32'h1000_0000, 32'h0B00_0000,
                                      32'h1100_0000, 32'h020C_0000};
  localparam logic [3:0]  VRC [NV] = '{4'd0, 4'd2, 4'd1, 4'd1, 4'd0};
  localparam logic [1:0]  VSW [NV] = '{2'd1, 2'd2, 2'd0, 2'd1, 2'd1};

  function automatic int divisor(input logic [3:0] c);
    int t[9] = '{32, 48, 64, 96, 128, 192, 256, 384, 512};
    return (c < 9) ? t[c] : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    // R10: reset state with master running config
    master = 1'b1; en = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mclk && !bclk && !lrck && !fs, "R10 outputs in reset", {mclk, bclk, lrck, fs}, 0);
    rst_n = 1'b1;
    en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      int mr, n, br, bh, bad, w, r;
      logic pm, pb, pl;
      real e;
      en = 1'b0; fw = VFW[i]; rc = VRC[i]; sw = VSW[i];
      repeat (4) @(negedge clk);
      w = 8 * (VSW[i] + 1); r = divisor(VRC[i]);
      chk(!err, "R8 legal config no error", err, 0);
      en = 1'b1;
      // R1/R2 average mclk rate
      mr = 0; pm = mclk;
      for (int k = 0; k < 2048; k++) begin
        @(negedge clk);
        if (mclk && !pm) mr++;
        pm = mclk;
      end
      e = 2048.0 * real'(VFW[i]) / 4294967296.0;
      chk((real'(mr) - e <= 1.5) && (e - real'(mr) <= 1.5), (i == 2) ? "R2 fractional mclk rate" : "R1 mclk rate", mr, e);
      // frame measurement
      while (!fs) @(negedge clk);
      chk(!lrck, "R6 lrck low at strobe", lrck, 0);
      @(negedge clk);
      chk(!fs, "R6 strobe one cycle", fs, 0);
      n = 1; br = 0; bh = 0; bad = 0; pb = bclk; pl = lrck;
      while (!fs) begin
        @(negedge clk);
        n++;
        if (bclk && !pb) begin br++; if (lrck) bh++; end
        if (lrck != pl && !(pb && !bclk)) bad++;
        pb = bclk; pl = lrck;
      end
      e = real'(r) * 4294967296.0 / real'(VFW[i]);
      chk((real'(n) - e <= 2.0) && (e - real'(n) <= 2.0), "R3 frame length", n, e);
      chk(br == 2 * w, "R4 bclk rises per frame", br, 2 * w);
      chk(bh == w, "R5 bclk rises in high half", bh, w);
      chk(bad == 0, "R5 lrck changes on bclk fall", bad, 0);
    end

    // R7: disabled master
    begin
      int act;
      en = 1'b0; fw = 32'h2000_0000; rc = 4'd0; sw = 2'd1;
      act = 0;
      @(negedge clk);
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (mclk || bclk || lrck) act++;
      end
      chk(act == 0, "R7 clocks idle when disabled", act, 0);
    end

    // R8: error cases
    begin
      int hi, mr;
      logic pm;
      sw = 2'd2; rc = 4'd0;
      @(negedge clk);
      chk(err, "R8 ratio 32 with 24-bit", err, 1);
      en = 1'b1; hi = 0; mr = 0; pm = mclk;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (bclk || lrck) hi++;
        if (mclk && !pm) mr++;
        pm = mclk;
      end
      chk(hi == 0, "R8 bclk/lrck frozen on error", hi, 0);
      chk(mr > 40, "R8 mclk still runs on error", mr, 50);
      rc = 4'd9; sw = 2'd1;
      @(negedge clk);
      chk(err, "R8 ratio code 9", err, 1);
      rc = 4'd8; sw = 2'd3;
      @(negedge clk);
      chk(err, "R8 width code 3", err, 1);
      rc = 4'd1; sw = 2'd2;
      @(negedge clk);
      chk(!err, "R8 boundary 48 with 24-bit legal", err, 0);
      en = 1'b0;
    end

    // R9: slave mode
    begin
      int mr;
      master = 1'b0; en = 1'b1; bpin = 1'b1; lpin = 1'b1;
      @(negedge clk);
      chk(!bclk, "R9 bclk delayed one cycle", bclk, 0);
      @(negedge clk);
      chk(bclk && lrck, "R9 pins after two cycles", {bclk, lrck}, 3);
      repeat (3) @(negedge clk);
      lpin = 1'b0; bpin = 1'b0;
      @(negedge clk);
      chk(!fs && lrck, "R9 no strobe before sync", {fs, lrck}, 1);
      @(negedge clk);
      chk(fs && !lrck, "R9 strobe on synced fall", {fs, lrck}, 2);
      @(negedge clk);
      chk(!fs, "R9 strobe one cycle", fs, 0);
      mr = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        bpin = ~bpin;
        if (mclk) mr++;
      end
      chk(mr == 0, "R9 no mclk in slave", mr, 0);
    end

    summary();
  end
endmodule